// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block keeps a 64-bit main counter that advances on tick pulses from an outside prescaler. Several comparator channels watch that counter. Each channel can raise its interrupt once or repeatedly, and each interrupt can be edge or level. Software reaches everything through single-cycle 32-bit register writes and combinational reads on an 8-bit byte address.

Each channel has a configuration word and a 64-bit comparator at two word offsets. A periodic channel uses a set-value bit, so one comparator write sequence loads the first match time and the next sequence loads the period. In 32-bit mode only the low word is compared, and the period is added modulo 2^32. Interrupts normally go to one of several lines picked by a routing field. A legacy-routing switch takes channels 0 and 1 off those lines and drives two dedicated outputs instead.

Register map: 0x00 identity, 0x04 tick period (femtoseconds), 0x08 general control (bit 0 run, bit 1 legacy routing), 0x0C status (bit n = channel n, write 1 clears), 0x10/0x14 counter low/high. Channel n sits at 0x20+0x10·n: +0 configuration, +4 comparator low, +8 comparator high.

Top module: `evt_timer`

## Requirements
- R1: While the run bit (bit 0 at 0x08) is set, each cycle with `tick_en` high adds exactly one to the 64-bit counter, with carry from the low word into the high word.
- R2: With the run bit clear the counter holds its value and both halves (0x10, 0x14) can be written. Counter writes while running are ignored.
- R3: The identity word holds NCH-1 in bits [4:0] and the legacy-routing capability in bit 8 (0x102 with defaults). The word at 0x04 returns the TICK_FS parameter.
- R4: A one-shot channel (configuration bit 1 clear) sets its status bit on the clock edge at which the counter steps onto the comparator value. Its comparator is never changed by hardware.
- R5: With periodic (bit 1) and set-value (bit 3) both set, comparator writes load the match time. A high-half write, or a low-half write in 32-bit mode, then clears set-value. After that, comparator writes load the period, and every match adds the period to the match time, which reads back at +4/+8.
- R6: In 32-bit mode (bit 4) a match needs only the low counter word to equal the low comparator word. Periodic reload then wraps modulo 2^32 and leaves the high comparator word alone.
- R7: In level mode (bit 2 set) a status bit stays set until a 1 is written to it at 0x0C. In edge mode it is high for exactly the one cycle after the matching edge.
- R8: With interrupt enable (bit 0) clear, a match sets no status bit and drives no output.
- R9: With legacy routing on, channel 0 drives `irq_leg_tmr` and channel 1 drives `irq_leg_clk`, and neither reaches `irq_line`. With it off, both legacy outputs stay low.
- R10: Otherwise a channel's status drives `irq_line[route]`, where route is configuration bits [10:8].
- R11: Configuration bit 5 reads 1 only on channels that can run periodic (PCAP_MASK), and bit 6 reads 0. On a channel that cannot run periodic, the periodic and set-value bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler tick; advances the counter while running |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_leg_tmr | output | 1 | Legacy timer interrupt (channel 0) |
| irq_leg_clk | output | 1 | Legacy clock interrupt (channel 1) |
| irq_line | output | NLINES | Routed interrupt lines |

## Verification
The assertions assume that each cycle carries at most one register write. This means a configuration write, a comparator write and a status clear for the same channel never land on the same edge. They also assume that `tick_en` is meaningful only as a per-cycle enable, not as an edge. The stimulus meets these assumptions by issuing writes one per cycle from a single task and by holding `tick_en` low except during counted tick bursts. Match times are placed so that only the channel under test can reach its comparator during each burst.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_TICKFS = 8'h04;
  localparam logic [7:0] OFS_GCFG   = 8'h08;
  localparam logic [7:0] OFS_STS    = 8'h0C;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam int unsigned CH_FIRST_BLK = 2;

  localparam logic [3:0] W_CFG    = 4'h0;
  localparam logic [3:0] W_CMP_LO = 4'h4;
  localparam logic [3:0] W_CMP_HI = 4'h8;

  localparam int unsigned CB_IEN   = 0;
  localparam int unsigned CB_PER   = 1;
  localparam int unsigned CB_LVL   = 2;
  localparam int unsigned CB_SETV  = 3;
  localparam int unsigned CB_M32   = 4;
  localparam int unsigned CB_PCAP  = 5;
  localparam int unsigned CB_MCAP  = 6;
  localparam int unsigned CB_ROUTE = 8;

  localparam int unsigned ID_LEG_BIT = 8;

  typedef struct packed {
    logic ien;
    logic per;
    logic lvl;
    logic setv;
    logic m32;
  } ch_mode_t;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          adv_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign adv_o     = run_i & tick_i;
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;
  assign cnt_en    = adv_o | (~run_i & (wr_lo_i | wr_hi_i));

  always_comb begin
    cnt_n = cnt_q;
    if (adv_o) begin
      cnt_n = cnt_nxt_o;
    end else if (!run_i) begin
      if (wr_lo_i) cnt_n[31:0]    = wdata_i;
      if (wr_hi_i) cnt_n[CW-1:32] = wdata_i[CW-33:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !tick_i |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter bit          PCAP = 1'b1,
  parameter int unsigned RW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [31:0]   wdata_i,
  input  logic          adv_i,
  input  logic [63:0]   cnt_nxt_i,
  input  logic          sts_clr_i,
  output logic [31:0]   cfg_o,
  output logic [63:0]   cmp_o,
  output logic [RW-1:0] route_o,
  output logic          sts_o
);
  ch_mode_t      mode_q, mode_n;
  logic [RW-1:0] route_q, route_n;
  logic [63:0]   match_q, match_n, prd_q, prd_n;
  logic          sts_q, sts_n;
  logic          hit, fire, to_match, mode_en, cmp_en;

  assign hit      = adv_i & (mode_q.m32 ? (cnt_nxt_i[31:0] == match_q[31:0])
                                        : (cnt_nxt_i == match_q));
  assign fire     = hit & mode_q.ien;
  assign to_match = ~mode_q.per | mode_q.setv;
  assign mode_en  = cfg_we_i | lo_we_i | hi_we_i;
  assign cmp_en   = hit | lo_we_i | hi_we_i;

  always_comb begin
    mode_n  = mode_q;
    route_n = route_q;
    match_n = match_q;
    prd_n   = prd_q;
    if (hit && mode_q.per) begin
      if (mode_q.m32) match_n[31:0] = match_q[31:0] + prd_q[31:0];
      else            match_n       = match_q + prd_q;
    end
    if (cfg_we_i) begin
      mode_n.ien  = wdata_i[CB_IEN];
      mode_n.per  = wdata_i[CB_PER] & PCAP;
      mode_n.lvl  = wdata_i[CB_LVL];
      mode_n.setv = wdata_i[CB_SETV] & PCAP;
      mode_n.m32  = wdata_i[CB_M32];
      route_n     = wdata_i[CB_ROUTE +: RW];
    end
    if (lo_we_i) begin
      if (to_match) match_n[31:0] = wdata_i;
      else          prd_n[31:0]   = wdata_i;
      if (mode_q.m32) mode_n.setv = 1'b0;
    end
    if (hi_we_i) begin
      if (to_match) match_n[63:32] = wdata_i;
      else          prd_n[63:32]   = wdata_i;
      mode_n.setv = 1'b0;
    end
    sts_n = mode_q.lvl ? ((sts_q & ~sts_clr_i) | fire) : fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      route_q <= '0;
    end else if (mode_en) begin
      mode_q  <= mode_n;
      route_q <= route_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      prd_q   <= '0;
    end else if (cmp_en) begin
      match_q <= match_n;
      prd_q   <= prd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_n;
  end

  always_comb begin
    cfg_o                 = '0;
    cfg_o[CB_IEN]         = mode_q.ien;
    cfg_o[CB_PER]         = mode_q.per;
    cfg_o[CB_LVL]         = mode_q.lvl;
    cfg_o[CB_SETV]        = mode_q.setv;
    cfg_o[CB_M32]         = mode_q.m32;
    cfg_o[CB_PCAP]        = PCAP;
    cfg_o[CB_MCAP]        = 1'b0;
    cfg_o[CB_ROUTE +: RW] = route_q;
  end

  assign cmp_o   = match_q;
  assign route_o = route_q;
  assign sts_o   = sts_q;

  // R7
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.lvl && sts_q && !sts_clr_i |=> sts_q);

  // R7
  edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q && !$past(mode_q.lvl) |-> $past(adv_i));

  // R4
  oneshot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.per && !lo_we_i && !hi_we_i |=> match_q == $past(match_q));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.ien && !mode_q.lvl |=> !sts_q);
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
  parameter int unsigned NCH    = 3,
  parameter int unsigned NLINES = 8,
  parameter int unsigned RW     = 3
) (
  input  logic [NCH-1:0]    ch_irq_i,
  input  logic [NCH*RW-1:0] route_i,
  input  logic              leg_en_i,
  output logic              leg_tmr_o,
  output logic              leg_clk_o,
  output logic [NLINES-1:0] line_o
);
  always_comb begin
    line_o = '0;
    for (int n = 0; n < NCH; n++) begin
      if (ch_irq_i[n] && !(leg_en_i && n < 2))
        line_o[route_i[n*RW +: RW]] = 1'b1;
    end
  end

  assign leg_tmr_o = leg_en_i & ch_irq_i[0];

  generate
    if (NCH > 1) begin : g_leg_clk
      assign leg_clk_o = leg_en_i & ch_irq_i[1];
    end else begin : g_no_leg_clk
      assign leg_clk_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned NCH       = 3,
  parameter int unsigned NLINES    = 8,
  parameter logic [31:0] TICK_FS   = 32'd69841279,
  parameter logic [31:0] PCAP_MASK = 32'h3,
  parameter bit          LEG_CAP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_leg_tmr,
  output logic              irq_leg_clk,
  output logic [NLINES-1:0] irq_line
);
  localparam int unsigned RW = $clog2(NLINES);
  localparam int unsigned CW = 64;

  logic              run_q, run_n, leg_q, leg_n, gcfg_we;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic              adv;
  logic [NCH-1:0]    sts;
  logic [NCH*RW-1:0] routes;
  logic [31:0]       ch_cfg [NCH];
  logic [63:0]       ch_cmp [NCH];
  logic [31:0]       id_word;

  assign gcfg_we = reg_wr && (reg_addr == OFS_GCFG);
  assign run_n   = reg_wdata[0];
  assign leg_n   = reg_wdata[1] & LEG_CAP;
  assign id_word = 32'(NCH - 1) | (32'(LEG_CAP) << ID_LEG_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (gcfg_we) begin
      run_q <= run_n;
      leg_q <= leg_n;
    end
  end

  evt_main_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .tick_i    (tick_en),
    .wr_lo_i   (reg_wr && reg_addr == OFS_CNT_LO),
    .wr_hi_i   (reg_wr && reg_addr == OFS_CNT_HI),
    .wdata_i   (reg_wdata),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .adv_o     (adv)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic blk;
      assign blk = reg_wr && (reg_addr[7:4] == 4'(n + CH_FIRST_BLK));
      evt_channel #(.PCAP(PCAP_MASK[n]), .RW(RW)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we_i  (blk && reg_addr[3:0] == W_CFG),
        .lo_we_i   (blk && reg_addr[3:0] == W_CMP_LO),
        .hi_we_i   (blk && reg_addr[3:0] == W_CMP_HI),
        .wdata_i   (reg_wdata),
        .adv_i     (adv),
        .cnt_nxt_i (cnt_nxt),
        .sts_clr_i (reg_wr && reg_addr == OFS_STS && reg_wdata[n]),
        .cfg_o     (ch_cfg[n]),
        .cmp_o     (ch_cmp[n]),
        .route_o   (routes[n*RW +: RW]),
        .sts_o     (sts[n])
      );
    end
  endgenerate

  evt_irq_route #(.NCH(NCH), .NLINES(NLINES), .RW(RW)) u_route (
    .ch_irq_i  (sts),
    .route_i   (routes),
    .leg_en_i  (leg_q),
    .leg_tmr_o (irq_leg_tmr),
    .leg_clk_o (irq_leg_clk),
    .line_o    (irq_line)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_ID:     reg_rdata = id_word;
      OFS_TICKFS: reg_rdata = TICK_FS;
      OFS_GCFG:   reg_rdata = {30'b0, leg_q, run_q};
      OFS_STS:    reg_rdata = 32'(sts);
      OFS_CNT_LO: reg_rdata = cnt[31:0];
      OFS_CNT_HI: reg_rdata = cnt[63:32];
      default:    reg_rdata = '0;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr[7:4] == 4'(n + CH_FIRST_BLK)) begin
        case (reg_addr[3:0])
          W_CFG:    reg_rdata = ch_cfg[n];
          W_CMP_LO: reg_rdata = ch_cmp[n][31:0];
          W_CMP_HI: reg_rdata = ch_cmp[n][63:32];
          default:  reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_leg_tmr, irq_leg_clk;
  logic [7:0]  irq_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_leg_tmr(irq_leg_tmr), .irq_leg_clk(irq_leg_clk), .irq_line(irq_line)
  );

  // Monitor: pops expected items and compares with the outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {22'b0, irq_leg_clk, irq_leg_tmr, irq_line} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_wr  = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    step();
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic irq_chk(input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      tick_en = 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state, R3
    rd(8'h00, 32'h102, "R3 id word");
    rd(8'h04, 32'd69841279, "R3 tick period");
    rd(8'h08, 32'h0, "reset gcfg");
    rd(8'h10, 32'h0, "reset counter");
    irq_chk(32'h0, "reset irq outputs");

    // R2 writes while stopped, hold while stopped
    wr(8'h10, 32'h100);
    wr(8'h14, 32'h5);
    rd(8'h10, 32'h100, "R2 write low while stopped");
    rd(8'h14, 32'h5, "R2 write high while stopped");
    ticks(3);
    rd(8'h10, 32'h100, "R2 frozen while stopped");

    // R1 counting
    wr(8'h08, 32'h1);
    ticks(5);
    rd(8'h10, 32'h105, "R1 count low");
    rd(8'h14, 32'h5, "R1 count high");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h105, "R2 write ignored while running");

    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h08, 32'h1);

    // R4 one-shot level on channel 0, route 3
    wr(8'h20, 32'h305);
    wr(8'h24, 32'd10);
    wr(8'h28, 32'h0);
    rd(8'h20, 32'h325, "R11 ch0 cfg readback");
    ticks(9);
    rd(8'h0C, 32'h0, "R4 no status before match");
    ticks(1);
    rd(8'h0C, 32'h1, "R4 status at match");
    irq_chk(32'h008, "R10 line 3 from ch0");
    ticks(5);
    rd(8'h0C, 32'h1, "R7 level sticky");
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R7 write one clears");
    irq_chk(32'h0, "R7 output drops after clear");
    rd(8'h24, 32'd10, "R4 comparator unchanged");

    // R9 legacy routing
    wr(8'h08, 32'h3);
    rd(8'h08, 32'h3, "R9 gcfg legacy readback");
    wr(8'h24, 32'd20);
    ticks(5);
    rd(8'h0C, 32'h1, "R9 ch0 status");
    irq_chk(32'h100, "R9 ch0 on legacy timer line only");
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h1);

    // R5 periodic edge channel 1, route 5; counter is 20
    wr(8'h30, 32'h50B);
    wr(8'h34, 32'd30);
    wr(8'h38, 32'h0);
    rd(8'h30, 32'h523, "R5 set-value cleared after match write");
    wr(8'h34, 32'd7);
    wr(8'h38, 32'h0);
    rd(8'h34, 32'd30, "R5 period write keeps match time");
    ticks(10);
    rd(8'h0C, 32'h2, "R5 first periodic match");
    irq_chk(32'h020, "R10 line 5 from ch1");
    rd(8'h0C, 32'h0, "R7 edge pulse one cycle");
    rd(8'h34, 32'd37, "R5 reload adds period");
    ticks(7);
    rd(8'h0C, 32'h2, "R5 second periodic match");
    rd(8'h34, 32'd44, "R5 second reload");

    // R8 interrupt enable clear; counter is 37
    wr(8'h30, 32'h500);
    wr(8'h34, 32'd40);
    ticks(3);
    rd(8'h0C, 32'h0, "R8 no status with enable clear");
    irq_chk(32'h0, "R8 no output with enable clear");

    // R6 / R11 channel 2, 32-bit match across carry
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h14, 32'h0);
    wr(8'h40, 32'h617);
    rd(8'h40, 32'h615, "R11 periodic bit forced off");
    wr(8'h44, 32'h2);
    wr(8'h48, 32'h77);
    wr(8'h08, 32'h1);
    ticks(18);
    rd(8'h0C, 32'h4, "R6 low-word match");
    irq_chk(32'h040, "R10 line 6 from ch2");
    rd(8'h14, 32'h1, "R1 carry into high word");
    wr(8'h0C, 32'h4);

    // R6 periodic reload modulo 2^32 on channel 0
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h20, 32'h1B);
    wr(8'h24, 32'hFFFF_FFF8);
    wr(8'h24, 32'h10);
    rd(8'h20, 32'h33, "R5 low write ends set-value in 32-bit mode");
    wr(8'h08, 32'h1);
    ticks(8);
    rd(8'h24, 32'h8, "R6 reload wraps low word");
    rd(8'h28, 32'h0, "R6 high word untouched");

    step();
    step();
    wait (sb.size() == 0);
    step();
    done = 1'b1;
    finish_run();
  end
endmodule